// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level translation table out of memory. The virtual page number is the top 20 bits of the address. Its upper 10 bits select an entry in a directory page, and its lower 10 bits select an entry in a second-level table page. The low 12 bits are the byte offset within a 4 KB page and pass through unchanged. The walker issues word reads and one word write on a simple request/acknowledge memory port. It runs one walk at a time and returns either a physical address or a 2-bit fault code.

A directory entry holds a valid flag and the frame number of a second-level table. A leaf entry holds a frame number and a set of flags: valid, read, write and execute permission, present, dirty and referenced. The walker checks these flags in priority order. A walk that succeeds writes the leaf back with the referenced flag set, and on a write access it also sets the dirty flag. Fault servicing and translation caching are left to other blocks.

Top module: `pt_walker`

## Requirements
- R1: On the cycle after `start` is seen while idle, the walker raises `mem_req` with `mem_we` low and `mem_addr` = (`root_frame` << 12) + vaddr[31:22]*4. Both `root_frame` and `vaddr` are sampled with `start`.
- R2: Once the directory word is acknowledged with bit 0 (valid) set, the next request reads `mem_addr` = (dir_word[31:12] << 12) + vaddr[21:12]*4.
- R3: A directory word with bit 0 clear ends the walk with fault code 1 (invalid). Only the one read has been made and no write follows.
- R4: A leaf word with bit 0 (valid) clear ends the walk with fault code 1.
- R5: A valid leaf word with bit 4 (present) clear ends the walk with fault code 2 (not present), and no write is made.
- R6: The access type `acc` is 0 = read, 1 = write, 2 = execute and 3 = reserved. These need leaf bit 1, bit 2 and bit 3 respectively. A reserved access is never permitted. A valid, present leaf that lacks the needed bit ends the walk with fault code 3 (protection). When more than one fault applies, invalid takes priority over not present, and not present over protection.
- R7: A walk with no fault reports `fault` = 0 and `paddr` = {leaf[31:12], vaddr[11:0]}. A faulting walk reports `paddr` = 0.
- R8: A walk with no fault makes exactly one write, to the leaf's address. The data is the leaf word with bit 6 (referenced) set, and with bit 5 (dirty) also set when `acc` = 1. All other bits are unchanged, so a read access keeps any dirty bit already set.
- R9: `busy` is high from the cycle after an accepted `start` until `done`. `done` is a one-cycle pulse with `busy` low. A `start` asserted while busy is ignored and does not change the walk in progress.
- R10: After reset `busy`, `done`, `mem_req` and `mem_we` are low and `fault` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk when idle |
| vaddr | input | 32 | Virtual address to translate |
| acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| root_frame | input | 20 | Frame number of the directory page |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| paddr | output | 32 | Translated physical address |
| fault | output | 2 | 0 none, 1 invalid, 2 not present, 3 protection |
| mem_req | output | 1 | One-cycle memory request pulse |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word address of the request (byte units) |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Response for the outstanding request, at least one cycle after it |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
The hardest cases to reach are the fault priorities: the outcome depends on several leaf flags together with the access type, and on whether the directory read even allows a second read. The bench covers this by sweeping all 128 combinations of the seven leaf flag bits against all four access types. For each walk it places a fresh directory and leaf word at addresses derived from the walk number. It also varies the response latency of the memory model, and it adds invalid directory words that carry stray bits. The case of a start arriving during a walk is produced by pulsing `start` with a different address in the middle of a walk.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_INVALID = 2'd1,
    FLT_ABSENT  = 2'd2,
    FLT_PROT    = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  // flag positions inside a table word
  localparam int BIT_VALID   = 0;
  localparam int BIT_READ    = 1;
  localparam int BIT_WRITE   = 2;
  localparam int BIT_EXEC    = 3;
  localparam int BIT_PRESENT = 4;
  localparam int BIT_DIRTY   = 5;
  localparam int BIT_REF     = 6;

endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int DIR_W   = 10,
  parameter int LEAF_W  = 10,
  parameter int OFF_W   = 12,
  parameter int ENTRY_W = 32
) (
  input  logic [VA_W-1:0]         va_new,
  input  logic [VA_W-1:0]         va_held,
  input  logic [PA_W-OFF_W-1:0]   root_frame,
  input  logic [ENTRY_W-1:0]      word,
  output logic [PA_W-1:0]         dir_addr,
  output logic [PA_W-1:0]         leaf_addr,
  output logic [PA_W-1:0]         phys_addr
);
  localparam int FRAME_W = PA_W - OFF_W;
  localparam int WORD_SH = $clog2(ENTRY_W / 8);

  logic [FRAME_W-1:0] word_frame;
  logic [DIR_W-1:0]   dir_idx;
  logic [LEAF_W-1:0]  leaf_idx;

  assign word_frame = word[ENTRY_W-1 -: FRAME_W];
  assign dir_idx    = va_new[VA_W-1 -: DIR_W];
  assign leaf_idx   = va_held[OFF_W +: LEAF_W];

  assign dir_addr  = {root_frame, {OFF_W{1'b0}}} + (PA_W'(dir_idx) << WORD_SH);
  assign leaf_addr = {word_frame, {OFF_W{1'b0}}} + (PA_W'(leaf_idx) << WORD_SH);
  assign phys_addr = {word_frame, va_held[OFF_W-1:0]};
endmodule

// File: rtl/pt_entry_check.sv
module pt_entry_check
  import pt_walker_pkg::*;
#(
  parameter int ENTRY_W = 32
) (
  input  logic [ENTRY_W-1:0] leaf,
  input  logic [1:0]         acc,
  output fault_e             verdict,
  output logic [ENTRY_W-1:0] updated
);
  logic allowed;

  always_comb begin
    unique case (acc)
      ACC_READ:  allowed = leaf[BIT_READ];
      ACC_WRITE: allowed = leaf[BIT_WRITE];
      ACC_EXEC:  allowed = leaf[BIT_EXEC];
      default:   allowed = 1'b0;
    endcase
  end

  always_comb begin
    if (!leaf[BIT_VALID])        verdict = FLT_INVALID;
    else if (!leaf[BIT_PRESENT]) verdict = FLT_ABSENT;
    else if (!allowed)           verdict = FLT_PROT;
    else                         verdict = FLT_NONE;
  end

  always_comb begin
    updated = leaf;
    updated[BIT_REF] = 1'b1;
    if (acc == ACC_WRITE) updated[BIT_DIRTY] = 1'b1;
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int DIR_W   = 10,
  parameter int LEAF_W  = 10,
  parameter int OFF_W   = 12,
  parameter int ENTRY_W = 32,
  localparam int FRAME_W = PA_W - OFF_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [VA_W-1:0]     vaddr,
  input  logic [1:0]          acc,
  input  logic [FRAME_W-1:0]  root_frame,
  output logic                busy,
  output logic                done,
  output logic [PA_W-1:0]     paddr,
  output logic [1:0]          fault,
  output logic                mem_req,
  output logic                mem_we,
  output logic [PA_W-1:0]     mem_addr,
  output logic [ENTRY_W-1:0]  mem_wdata,
  input  logic                mem_ack,
  input  logic [ENTRY_W-1:0]  mem_rdata
);
  typedef enum logic [1:0] {ST_IDLE, ST_DIR, ST_LEAF, ST_WB} state_e;

  state_e             state;
  logic [VA_W-1:0]    va_q;
  logic [1:0]         acc_q;
  logic [PA_W-1:0]    pa_q;

  logic [PA_W-1:0]    dir_addr, leaf_addr, phys_addr;
  fault_e             verdict;
  logic [ENTRY_W-1:0] updated;

  pt_addr_gen #(
    .VA_W(VA_W), .PA_W(PA_W), .DIR_W(DIR_W), .LEAF_W(LEAF_W),
    .OFF_W(OFF_W), .ENTRY_W(ENTRY_W)
  ) u_addr (
    .va_new(vaddr), .va_held(va_q), .root_frame(root_frame),
    .word(mem_rdata), .dir_addr(dir_addr), .leaf_addr(leaf_addr),
    .phys_addr(phys_addr)
  );

  pt_entry_check #(.ENTRY_W(ENTRY_W)) u_check (
    .leaf(mem_rdata), .acc(acc_q), .verdict(verdict), .updated(updated)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      busy      <= 1'b0;
      done      <= 1'b0;
      paddr     <= '0;
      fault     <= FLT_NONE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      va_q      <= '0;
      acc_q     <= '0;
      pa_q      <= '0;
    end else begin
      mem_req <= 1'b0;
      mem_we  <= 1'b0;
      done    <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            va_q     <= vaddr;
            acc_q    <= acc;
            busy     <= 1'b1;
            mem_req  <= 1'b1;
            mem_addr <= dir_addr;
            state    <= ST_DIR;
          end
        end
        ST_DIR: begin
          if (mem_ack) begin
            if (!mem_rdata[BIT_VALID]) begin
              done  <= 1'b1;
              busy  <= 1'b0;
              fault <= FLT_INVALID;
              paddr <= '0;
              state <= ST_IDLE;
            end else begin
              mem_req  <= 1'b1;
              mem_addr <= leaf_addr;
              state    <= ST_LEAF;
            end
          end
        end
        ST_LEAF: begin
          if (mem_ack) begin
            if (verdict != FLT_NONE) begin
              done  <= 1'b1;
              busy  <= 1'b0;
              fault <= verdict;
              paddr <= '0;
              state <= ST_IDLE;
            end else begin
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_wdata <= updated;
              pa_q      <= phys_addr;
              state     <= ST_WB;
            end
          end
        end
        ST_WB: begin
          if (mem_ack) begin
            done  <= 1'b1;
            busy  <= 1'b0;
            fault <= FLT_NONE;
            paddr <= pa_q;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic [VA_W-1:0] vaddr,
  input logic            busy,
  input logic            done,
  input logic [PA_W-1:0] paddr,
  input logic [1:0]      fault,
  input logic            mem_req,
  input logic            mem_we
);
  logic [VA_W-1:0] va_seen;
  always_ff @(posedge clk) begin
    if (rst) va_seen <= '0;
    else if (start && !busy) va_seen <= vaddr;
  end

  assert_launch_R1: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && mem_req && !mem_we));
  assert_req_only_busy_R9: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !mem_req));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_write_is_req_R8: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_req);
  assert_offset_kept_R7: assert property (@(posedge clk) disable iff (rst)
    (done && fault == 2'd0) |-> (paddr[OFF_W-1:0] == va_seen[OFF_W-1:0]));
  assert_fault_zero_pa_R7: assert property (@(posedge clk) disable iff (rst)
    (done && fault != 2'd0) |-> (paddr == '0));
endmodule

bind pt_walker pt_walker_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .vaddr(vaddr), .busy(busy),
  .done(done), .paddr(paddr), .fault(fault), .mem_req(mem_req), .mem_we(mem_we)
);

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [19:0] ROOT = 20'd1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] vaddr = '0;
  logic [1:0]  acc = '0;
  logic        busy, done, mem_req, mem_we, mem_ack;
  logic [31:0] paddr, mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  fault;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst(rst), .start(start), .vaddr(vaddr), .acc(acc),
    .root_frame(ROOT), .busy(busy), .done(done), .paddr(paddr), .fault(fault),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // memory model: 4 frames of 1024 words, frame taken from addr[13:12]
  logic [31:0] mem [0:4095];
  int          lat = 0;
  int          cnt;
  logic        pend;
  logic [31:0] p_addr;
  int          n_rd, n_wr;
  logic [31:0] rd_prev, rd_last, wr_addr, wr_data;

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (rst) begin
      pend <= 1'b0; n_rd <= 0; n_wr <= 0; cnt <= 0;
      mem_rdata <= '0; p_addr <= '0;
      rd_prev <= '0; rd_last <= '0; wr_addr <= '0; wr_data <= '0;
    end else begin
      if (pend) begin
        if (cnt == 0) begin
          mem_ack   <= 1'b1;
          mem_rdata <= mem[p_addr[13:2]];
          pend      <= 1'b0;
        end else cnt <= cnt - 1;
      end
      if (mem_req) begin
        pend <= 1'b1; cnt <= lat; p_addr <= mem_addr;
        if (mem_we) begin
          n_wr <= n_wr + 1; wr_addr <= mem_addr; wr_data <= mem_wdata;
        end else begin
          n_rd <= n_rd + 1; rd_prev <= rd_last; rd_last <= mem_addr;
        end
      end
    end
  end

  int n_cmp = 0, n_bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
    if (!ok) begin
      n_cmp++; n_bad++;
      $display("FAIL R9: actual no done expected done within 200 cycles");
    end
  endtask

  // one complete walk with expectations computed from the flag rules
  task automatic walk(input int d, input int l, input int off, input int lf,
                      input logic [31:0] dword, input logic [31:0] leaf,
                      input logic [1:0] a);
    int r0, w0;
    bit ok;
    logic [31:0] va, dir_a, leaf_a, exp_wb;
    logic [1:0]  exp_f;
    logic        perm;
    va     = (32'(d) << 22) | (32'(l) << 12) | 32'(off);
    dir_a  = (32'(ROOT) << 12) + 32'(d) * 4;
    leaf_a = (32'(lf) << 12) + 32'(l) * 4;
    mem[dir_a[13:2]] = dword;
    if (dword[0]) mem[leaf_a[13:2]] = leaf;
    perm = (a == 2'd0) ? leaf[1] : (a == 2'd1) ? leaf[2] : (a == 2'd2) ? leaf[3] : 1'b0;
    if (!dword[0] || !leaf[0]) exp_f = 2'd1;
    else if (!leaf[4])         exp_f = 2'd2;
    else if (!perm)            exp_f = 2'd3;
    else                       exp_f = 2'd0;
    exp_wb = leaf | 32'h40 | ((a == 2'd1) ? 32'h20 : 32'h0);
    r0 = n_rd; w0 = n_wr;
    @(negedge clk);
    vaddr = va; acc = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R1 launch", {31'd0, mem_req & ~mem_we & busy}, 32'd1);
    chk("R1 dir addr", mem_addr, dir_a);
    vaddr = ~va;
    wait_done(ok);
    if (!ok) finish_run();
    chk("R9 idle at done", {31'd0, busy}, 32'd0);
    if (!dword[0]) begin
      chk("R3 fault", {30'd0, fault}, 32'd1);
      chk("R3 one read", 32'(n_rd - r0), 32'd1);
      chk("R3 no write", 32'(n_wr - w0), 32'd0);
      chk("R7 pa zero", paddr, 32'd0);
    end else begin
      chk("R2 leaf addr", rd_last, leaf_a);
      chk("R2 two reads", 32'(n_rd - r0), 32'd2);
      chk((exp_f == 2'd1) ? "R4 fault" : (exp_f == 2'd2) ? "R5 fault" : "R6 fault",
          {30'd0, fault}, {30'd0, exp_f});
      if (exp_f == 2'd0) begin
        chk("R7 paddr", paddr, {leaf[31:12], off[11:0]});
        chk("R8 one write", 32'(n_wr - w0), 32'd1);
        chk("R8 write addr", wr_addr, leaf_a);
        chk("R8 write data", wr_data, exp_wb);
      end else begin
        chk("R5 no write on fault", 32'(n_wr - w0), 32'd0);
        chk("R7 pa zero", paddr, 32'd0);
      end
    end
    @(negedge clk);
    chk("R9 done pulse", {31'd0, done}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R10 busy", {31'd0, busy}, 32'd0);
    chk("R10 done", {31'd0, done}, 32'd0);
    chk("R10 req", {31'd0, mem_req | mem_we}, 32'd0);
    chk("R10 fault", {30'd0, fault}, 32'd0);
    rst = 1'b0;

    // invalid directory words carrying stray bits
    for (int k = 0; k < 6; k++) begin
      lat = k % 3;
      walk(k * 151 % 1024, k * 7, k * 333 % 4096, 2,
           (32'(2) << 12) | 32'(k * 2), 32'h0000_0055, 2'(k));
    end

    // every leaf flag combination against every access type
    for (int c = 0; c < 128; c++) begin
      for (int a = 0; a < 4; a++) begin
        int lf;
        lf  = 2 + (c % 2);
        lat = (c + a) % 3;
        walk((c * 37 + a) % 1024, (c * 13 + a * 7) % 1024, (c * 291 + a) % 4096, lf,
             (32'(lf) << 12) | 32'h1,
             ((32'h8_0000 + 32'(c * 4 + a)) << 12) | 32'(c), 2'(a));
      end
    end

    // start while busy must be ignored (R9)
    begin
      int r0;
      bit ok;
      lat = 2;
      mem[1024 + 5] = (32'd3 << 12) | 32'h1;
      mem[3 * 1024 + 9] = (32'hABCDE << 12) | 32'h57;
      r0 = n_rd;
      @(negedge clk);
      vaddr = (32'd5 << 22) | (32'd9 << 12) | 32'h123; acc = 2'd0; start = 1'b1;
      @(negedge clk); start = 1'b0;
      @(negedge clk);
      vaddr = (32'd7 << 22) | 32'h456; acc = 2'd3; start = 1'b1;
      @(negedge clk); start = 1'b0;
      wait_done(ok);
      if (!ok) finish_run();
      chk("R9 ignored start fault", {30'd0, fault}, 32'd0);
      chk("R9 ignored start paddr", paddr, 32'hABCDE123);
      repeat (10) @(negedge clk);
      chk("R9 no extra walk", 32'(n_rd - r0), 32'd2);
      chk("R9 idle after", {31'd0, busy}, 32'd0);
    end
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R9: actual global timeout expected completion");
    finish_run();
  end
endmodule